// File: doc/BRIEF.md
# Two-Level Adaptive Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps two tables. The first holds branch history: each entry has an address tag and a short shift register of recent outcomes. The second holds pattern counters: each entry has an address tag and one two-bit saturating counter for every possible history value. A prediction reads the history for the branch address. That history value then picks one counter in the pattern entry for the same address. The top bit of that counter gives the predicted direction.

The number of entries in each table sets the prediction scheme, with no mode input. A table with one entry is global: every branch shares it and it needs no tag. A table with several entries is per-address: it is direct-mapped by the low address bits and checked against a full-address tag. This gives four schemes: global history with global patterns, global history with per-address patterns, per-address history with global patterns, and per-address history with per-address patterns.

The fetch stage uses the probe port and gets hit and taken back one cycle later. The resolve stage uses the update port once the branch outcome is known. On an update that hits, the selected counter is trained and the outcome is shifted into the history. On an update that misses, nothing is trained and fresh entries are allocated in the per-address tables that lack the address.

Top module: `adaptive_dir_predictor`

## Requirements
- R1: A table with exactly one entry is global. It is present for every address, it is shared by all addresses and it has no tag check, so with one entry in both tables every probe hits.
- R2: A table with more than one entry (a power of two) is per-address. Its entry index is the low log2(entries) bits of the address. The entry is present only if it is valid and its stored tag equals the full address.
- R3: A probe with probe_valid high in cycle t gives probe_rsp_valid high in cycle t+1, with probe_hit high exactly when the address is present in both tables. When probe_rsp_valid is low, probe_hit and probe_taken are low.
- R4: probe_taken is high only on a hit, and then it equals bit 1 of the counter selected by the history value of the address's history entry.
- R5: An update that hits moves the selected counter up by one when upd_taken is 1 and down by one when it is 0. The counter saturates at 0 and 3.
- R6: An update that hits shifts the history register left by one and places upd_taken in bit 0, dropping the oldest bit. The counter trained in the same cycle is the one selected by the history before the shift.
- R7: An update that misses trains nothing. Each per-address table that lacks the address overwrites the indexed entry: it becomes valid with the address as tag, with history 0 or with all counters at 01. A table that already holds the address keeps its entry unchanged.
- R8: After reset, per-address entries are invalid, global history is 0 and global counters are all 01 (weakly not-taken).
- R9: A probe and an update in the same cycle both see the state from before that cycle's update. The update takes effect for probes issued in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_valid | input | 1 | Probe request this cycle |
| probe_addr | input | ADDR_W | Address to predict |
| probe_rsp_valid | output | 1 | Probe response valid (one cycle after the request) |
| probe_hit | output | 1 | Address present in every table the scheme requires |
| probe_taken | output | 1 | Predicted taken |
| upd_valid | input | 1 | Resolved conditional branch this cycle |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The assertions check on every cycle that the response follows the probe by one cycle and only a probe, that hit and taken are low without a response, that a taken prediction always comes with a hit, and that the fully global scheme always hits. Only the bench's scenarios can show counter saturation, the order of history shift and training, eviction of aliasing addresses, partial allocation when one table hits, and same-cycle probe-versus-update ordering. The bench shows these by running four instances, one per scheme, against a behavioural model.

// File: rtl/dirpred_pkg.sv
package dirpred_pkg;
    typedef logic [1:0] ctr_t;
    localparam ctr_t CTR_INIT = 2'b01;
    localparam ctr_t CTR_MAX  = 2'b11;
    localparam ctr_t CTR_MIN  = 2'b00;
endpackage

// File: rtl/dirpred_table_match.sv
module dirpred_table_match #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 16,
    localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]             valid,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
    input  logic [ADDR_W-1:0]              addr,
    output logic [IW-1:0]                  idx,
    output logic                           present
);
    generate
        if (ENTRIES == 1) begin : g_global
            logic unused_bits;
            assign unused_bits = ^{valid, tags, addr};
            assign idx         = '0;
            assign present     = 1'b1;
        end else begin : g_per_addr
            assign idx     = addr[IW-1:0];
            assign present = valid[idx] && (tags[idx] == addr);
        end
    endgenerate
endmodule

// File: rtl/dirpred_sat_ctr.sv
module dirpred_sat_ctr
    import dirpred_pkg::*;
(
    input  ctr_t cur,
    input  logic up,
    output ctr_t nxt
);
    always_comb begin
        nxt = cur;
        if (up) begin
            if (cur != CTR_MAX) nxt = cur + 2'd1;
        end else begin
            if (cur != CTR_MIN) nxt = cur - 2'd1;
        end
    end
endmodule

// File: rtl/adaptive_dir_predictor.sv
module adaptive_dir_predictor
    import dirpred_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int HIST_W     = 3,
    parameter int HT_ENTRIES = 4,
    parameter int PT_ENTRIES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              probe_valid,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_rsp_valid,
    output logic              probe_hit,
    output logic              probe_taken,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_taken
);
    localparam int CTRS  = 1 << HIST_W;
    localparam int HT_IW = (HT_ENTRIES > 1) ? $clog2(HT_ENTRIES) : 1;
    localparam int PT_IW = (PT_ENTRIES > 1) ? $clog2(PT_ENTRIES) : 1;

    typedef struct packed {
        logic [HT_ENTRIES-1:0]             ht_valid;
        logic [HT_ENTRIES-1:0][ADDR_W-1:0] ht_tag;
        logic [HT_ENTRIES-1:0][HIST_W-1:0] ht_hist;
        logic [PT_ENTRIES-1:0]             pt_valid;
        logic [PT_ENTRIES-1:0][ADDR_W-1:0] pt_tag;
        logic [PT_ENTRIES-1:0][CTRS-1:0][1:0] pt_ctr;
        logic                              rsp_valid;
        logic                              rsp_hit;
        logic                              rsp_taken;
    } state_t;

    state_t state_q, state_d, state_rst;

    // lookups for the probe path and the update path
    logic [HT_IW-1:0]  p_hi, u_hi;
    logic [PT_IW-1:0]  p_pi, u_pi;
    logic              p_hpres, p_ppres, u_hpres, u_ppres;
    logic [HIST_W-1:0] p_hist, u_hist;
    ctr_t              p_ctr, u_ctr, u_ctr_nxt;

    dirpred_table_match #(.ENTRIES(HT_ENTRIES), .ADDR_W(ADDR_W)) probe_ht_i (
        .valid(state_q.ht_valid), .tags(state_q.ht_tag), .addr(probe_addr),
        .idx(p_hi), .present(p_hpres));
    dirpred_table_match #(.ENTRIES(PT_ENTRIES), .ADDR_W(ADDR_W)) probe_pt_i (
        .valid(state_q.pt_valid), .tags(state_q.pt_tag), .addr(probe_addr),
        .idx(p_pi), .present(p_ppres));
    dirpred_table_match #(.ENTRIES(HT_ENTRIES), .ADDR_W(ADDR_W)) upd_ht_i (
        .valid(state_q.ht_valid), .tags(state_q.ht_tag), .addr(upd_addr),
        .idx(u_hi), .present(u_hpres));
    dirpred_table_match #(.ENTRIES(PT_ENTRIES), .ADDR_W(ADDR_W)) upd_pt_i (
        .valid(state_q.pt_valid), .tags(state_q.pt_tag), .addr(upd_addr),
        .idx(u_pi), .present(u_ppres));

    assign p_hist = state_q.ht_hist[p_hi];
    assign p_ctr  = state_q.pt_ctr[p_pi][p_hist];
    assign u_hist = state_q.ht_hist[u_hi];
    assign u_ctr  = state_q.pt_ctr[u_pi][u_hist];

    dirpred_sat_ctr train_i (.cur(u_ctr), .up(upd_taken), .nxt(u_ctr_nxt));

    always_comb begin
        state_rst = '0;
        for (int e = 0; e < PT_ENTRIES; e++) begin
            for (int c = 0; c < CTRS; c++) state_rst.pt_ctr[e][c] = CTR_INIT;
        end
    end

    always_comb begin
        state_d           = state_q;
        state_d.rsp_valid = probe_valid;
        state_d.rsp_hit   = probe_valid && p_hpres && p_ppres;
        state_d.rsp_taken = probe_valid && p_hpres && p_ppres && p_ctr[1];

        if (upd_valid) begin
            if (u_hpres && u_ppres) begin
                // train with the old history, then shift the outcome in
                state_d.pt_ctr[u_pi][u_hist] = u_ctr_nxt;
                state_d.ht_hist[u_hi]        = HIST_W'({u_hist, upd_taken});
            end else begin
                if (!u_hpres) begin
                    state_d.ht_valid[u_hi] = 1'b1;
                    state_d.ht_tag[u_hi]   = upd_addr;
                    state_d.ht_hist[u_hi]  = '0;
                end
                if (!u_ppres) begin
                    state_d.pt_valid[u_pi] = 1'b1;
                    state_d.pt_tag[u_pi]   = upd_addr;
                    for (int c = 0; c < CTRS; c++) state_d.pt_ctr[u_pi][c] = CTR_INIT;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= state_rst;
        else        state_q <= state_d;
    end

    assign probe_rsp_valid = state_q.rsp_valid;
    assign probe_hit       = state_q.rsp_hit;
    assign probe_taken     = state_q.rsp_taken;
endmodule

// File: rtl/dirpred_checker.sv
module dirpred_checker #(
    parameter bit FULLY_GLOBAL = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic probe_valid,
    input logic probe_rsp_valid,
    input logic probe_hit,
    input logic probe_taken
);
    AST_RSP_FOLLOWS_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid |=> probe_rsp_valid); // R3
    AST_NO_RSP_WITHOUT_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !probe_valid |=> !probe_rsp_valid); // R3
    AST_IDLE_OUTPUTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !probe_rsp_valid |-> (!probe_hit && !probe_taken)); // R3
    AST_TAKEN_IMPLIES_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        probe_taken |-> probe_hit); // R4
    AST_GLOBAL_ALWAYS_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (FULLY_GLOBAL && probe_valid) |=> probe_hit); // R1
endmodule

bind adaptive_dir_predictor dirpred_checker #(
    .FULLY_GLOBAL((HT_ENTRIES == 1) && (PT_ENTRIES == 1))
) chk_i (
    .clk(clk), .rst_n(rst_n), .probe_valid(probe_valid),
    .probe_rsp_valid(probe_rsp_valid), .probe_hit(probe_hit), .probe_taken(probe_taken)
);

// File: tb/adaptive_dir_predictor_tb_top.sv
`timescale 1ns/1ps
module adaptive_dir_predictor_tb_top;
    localparam int AW = 16;
    localparam int HW = 3;
    localparam int NK = 4;

    // scheme k: 0 = per/per, 1 = global/global, 2 = global/per, 3 = per/global
    int EH[NK] = '{4, 1, 1, 4};
    int EP[NK] = '{2, 1, 4, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pv = 1'b0, uv = 1'b0, ut = 1'b0;
    logic [AW-1:0] pa = '0, ua = '0;
    logic rv[NK], hit[NK], tk[NK];

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    adaptive_dir_predictor #(.ADDR_W(AW), .HIST_W(HW), .HT_ENTRIES(4), .PT_ENTRIES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .probe_valid(pv), .probe_addr(pa),
        .probe_rsp_valid(rv[0]), .probe_hit(hit[0]), .probe_taken(tk[0]),
        .upd_valid(uv), .upd_addr(ua), .upd_taken(ut));
    adaptive_dir_predictor #(.ADDR_W(AW), .HIST_W(HW), .HT_ENTRIES(1), .PT_ENTRIES(1)) dut_gag_i (
        .clk(clk), .rst_n(rst_n), .probe_valid(pv), .probe_addr(pa),
        .probe_rsp_valid(rv[1]), .probe_hit(hit[1]), .probe_taken(tk[1]),
        .upd_valid(uv), .upd_addr(ua), .upd_taken(ut));
    adaptive_dir_predictor #(.ADDR_W(AW), .HIST_W(HW), .HT_ENTRIES(1), .PT_ENTRIES(4)) dut_gap_i (
        .clk(clk), .rst_n(rst_n), .probe_valid(pv), .probe_addr(pa),
        .probe_rsp_valid(rv[2]), .probe_hit(hit[2]), .probe_taken(tk[2]),
        .upd_valid(uv), .upd_addr(ua), .upd_taken(ut));
    adaptive_dir_predictor #(.ADDR_W(AW), .HIST_W(HW), .HT_ENTRIES(4), .PT_ENTRIES(1)) dut_pag_i (
        .clk(clk), .rst_n(rst_n), .probe_valid(pv), .probe_addr(pa),
        .probe_rsp_valid(rv[3]), .probe_hit(hit[3]), .probe_taken(tk[3]),
        .upd_valid(uv), .upd_addr(ua), .upd_taken(ut));

    // behavioural reference model
    bit m_hv[NK][4];
    int m_ht[NK][4];
    int m_hh[NK][4];
    bit m_pv[NK][4];
    int m_pt[NK][4];
    int m_pc[NK][4][8];
    bit e_rv[NK], e_hit[NK], e_tk[NK];

    task automatic model_reset();
        for (int k = 0; k < NK; k++) begin
            for (int e = 0; e < 4; e++) begin
                m_hv[k][e] = 0; m_ht[k][e] = 0; m_hh[k][e] = 0;
                m_pv[k][e] = 0; m_pt[k][e] = 0;
                for (int c = 0; c < 8; c++) m_pc[k][e][c] = 1;
            end
            e_rv[k] = 0; e_hit[k] = 0; e_tk[k] = 0;
        end
    endtask

    task automatic lookup(input int k, input int a, output int hi, output int pi,
                          output bit hp, output bit pp);
        hi = (EH[k] == 1) ? 0 : (a % EH[k]);
        pi = (EP[k] == 1) ? 0 : (a % EP[k]);
        hp = (EH[k] == 1) ? 1'b1 : (m_hv[k][hi] && m_ht[k][hi] == a);
        pp = (EP[k] == 1) ? 1'b1 : (m_pv[k][pi] && m_pt[k][pi] == a);
    endtask

    task automatic model_step(input bit p_v, input int p_a, input bit u_v, input int u_a,
                              input bit u_t);
        int hi, pi, h, c;
        bit hp, pp;
        for (int k = 0; k < NK; k++) begin
            lookup(k, p_a, hi, pi, hp, pp);
            e_rv[k]  = p_v;
            e_hit[k] = p_v && hp && pp;
            e_tk[k]  = e_hit[k] && (m_pc[k][pi][m_hh[k][hi]] >= 2);
            if (u_v) begin
                lookup(k, u_a, hi, pi, hp, pp);
                if (hp && pp) begin
                    h = m_hh[k][hi];
                    c = m_pc[k][pi][h];
                    if (u_t) c = (c < 3) ? c + 1 : 3;
                    else     c = (c > 0) ? c - 1 : 0;
                    m_pc[k][pi][h] = c;
                    m_hh[k][hi] = ((h << 1) | int'(u_t)) & 7;
                end else begin
                    if (!hp) begin
                        m_hv[k][hi] = 1; m_ht[k][hi] = u_a; m_hh[k][hi] = 0;
                    end
                    if (!pp) begin
                        m_pv[k][pi] = 1; m_pt[k][pi] = u_a;
                        for (int j = 0; j < 8; j++) m_pc[k][pi][j] = 1;
                    end
                end
            end
        end
    endtask

    task automatic cmp(input string req, input string what, input int k,
                       input bit act, input bit exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s scheme%0d actual=%0b expected=%0b t=%0t",
                     req, what, k, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string req);
        for (int k = 0; k < NK; k++) begin
            cmp(req, "rsp_valid", k, rv[k], e_rv[k]);
            cmp(req, "hit", k, hit[k], e_hit[k]);
            cmp(req, "taken", k, tk[k], e_tk[k]);
        end
    endtask

    // called at a falling edge; result compared at the next falling edge
    task automatic step(input bit p_v, input int p_a, input bit u_v, input int u_a,
                        input bit u_t, input string req);
        pv = p_v; pa = AW'(p_a); uv = u_v; ua = AW'(u_a); ut = u_t;
        model_step(p_v, p_a, u_v, u_a, u_t);
        @(negedge clk);
        compare_all(req);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    localparam int A = 'h0010;  // index 0 in 4- and 2-entry tables
    localparam int B = 'h0021;  // index 1
    localparam int C = 'h0014;  // aliases A

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        compare_all("R8");
        rst_n = 1'b1;
        // R8/R1: first probe after reset: global scheme hits weakly not-taken, per-address misses
        step(1, A, 0, 0, 0, "R8");
        cmp("R1", "gag_hit", 1, hit[1], 1'b1);
        cmp("R8", "pap_hit", 0, hit[0], 1'b0);
        // R7/R9: allocate A while probing A in the same cycle
        step(1, A, 1, A, 1, "R9");
        step(1, A, 0, 0, 0, "R7");
        cmp("R7", "pap_hit_after_alloc", 0, hit[0], 1'b1);
        // R5/R6: drive A taken repeatedly, probing alongside
        for (int i = 0; i < 10; i++) step(1, A, 1, A, 1, "R5");
        step(1, A, 0, 0, 0, "R4");
        cmp("R4", "pap_taken_trained", 0, tk[0], 1'b1);
        for (int i = 0; i < 10; i++) step(1, A, 1, A, 0, "R5");
        step(1, A, 0, 0, 0, "R4");
        cmp("R5", "pap_taken_untrained", 0, tk[0], 1'b0);
        // R6: alternating pattern on B
        for (int i = 0; i < 24; i++) step(1, B, 1, B, (i % 2) == 0, "R6");
        // R2/R7: alias C evicts A in per-address tables
        step(0, 0, 1, C, 1, "R7");
        step(1, A, 0, 0, 0, "R2");
        cmp("R2", "pap_alias_evicted", 0, hit[0], 1'b0);
        cmp("R2", "gap_other_index", 2, hit[2], 1'b0);
        // R3: idle cycles
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, "R3");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            int sel_p = $urandom_range(0, 5);
            int sel_u = $urandom_range(0, 5);
            int addrs[6] = '{'h0010, 'h0014, 'h0021, 'h0032, 'h0043, 'h1010};
            step($urandom_range(0, 3) != 0, addrs[sel_p], $urandom_range(0, 2) != 0,
                 addrs[sel_u], $urandom_range(0, 3) != 0, "R3");
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule